// File: doc/BRIEF.md
# Round-Robin Lattice Telemetry Framer

This block samples a bank of free-running iterator cores, one core per step, and turns each sample into a fixed nine-byte telemetry frame. The frame goes into a byte-wide transmit FIFO that feeds a serial line. A global step counter numbers every frame, and the reported core is always that counter modulo the number of cores. As a result, any one core reappears exactly once per sweep, and its consecutive frames are spaced by the core count in the counter.

The block never waits for a receiver. A programmable divider sets the issue rate. A frame is started only when the FIFO reports room for all nine bytes. Ticks that arrive while a frame cannot start merge into a single pending request. Each frame carries only the upper 24 bits of a core's 32-bit state, and the counter is carried at its full 32-bit width.

Top module: `lattice_tlm_framer`

## Requirements
- R1: Every frame is 9 bytes long. The bytes are written to the FIFO on 9 consecutive clock cycles, with a write strobe in each. Byte 0 is the sync value 0xA5, byte 1 is the core index, bytes 2..5 are the counter (most significant byte first), and bytes 6..8 are the core's state bits [31:8] (most significant byte first).
- R2: The core index in a frame equals the frame's counter value modulo 49.
- R3: The counter in consecutive frames increases by exactly one. This includes the step from 0x00FFFFFF to 0x01000000, whose frame reports core 8.
- R4: Two consecutive frames from the same core carry counter values that differ by exactly 49.
- R5: The state field holds bits [31:8] of the selected core at the time the frame starts. The low 8 state bits have no effect on the frame.
- R6: A frame starts only when the FIFO free-slot count is at least 9. While the count stays below 9, no byte is written.
- R7: With room in the FIFO, frames start every max(D+1, 10) cycles, where D is the divider input.
- R8: While reset is held, no byte is written. The first frame after reset carries the counter's reset value, set by the parameter N_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_div_i | input | 16 | Divider value D; a frame request is raised every D+1 cycles |
| core_state_i | input | 1568 | 49 core states of 32 bits each; core k occupies bits [32k+31:32k] |
| fifo_free_i | input | 8 | Number of free byte slots in the transmit FIFO |
| fifo_wr_en_o | output | 1 | FIFO write strobe |
| fifo_wr_data_o | output | 8 | FIFO write byte |

## Verification
The checker assumes that the free-slot count never drops during a frame except through the block's own writes. It therefore looks at the count only in the cycle before a frame starts. It also assumes the divider value changes only between frames, so that the spacing rule covers intervals that follow at least one full period at the new value. The stimulus keeps to both assumptions: it changes the free count and the divider only on falling edges, lets in-flight frames drain before it measures, and holds each setting for many frame periods. The counter's reset value is placed ten steps below 2^24, so a short run crosses that carry.

// File: rtl/ltf_pkg.sv
`timescale 1ns/1ps
package ltf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;

  function automatic int unsigned width_of(input int unsigned count);
    return (count <= 1) ? 1 : $clog2(count);
  endfunction
endpackage

// File: rtl/ltf_tick_gen.sv
`timescale 1ns/1ps
module ltf_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    tick_o = (cnt_q >= div_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ltf_core_sel.sv
`timescale 1ns/1ps
module ltf_core_sel #(
  parameter int unsigned NCORES   = 49,
  parameter int unsigned STATE_W  = 32,
  parameter int unsigned KEEP_LSB = 8,
  parameter int unsigned CNT_W    = 32,
  parameter logic [CNT_W-1:0] N_INIT = '0,
  localparam int unsigned IDX_W   = ltf_pkg::width_of(NCORES),
  localparam int unsigned X_W     = STATE_W - KEEP_LSB
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       advance_i,
  input  logic [NCORES*STATE_W-1:0]  core_state_i,
  output logic [IDX_W-1:0]           idx_o,
  output logic [CNT_W-1:0]           n_o,
  output logic [X_W-1:0]             x_o
);
  localparam logic [IDX_W-1:0] IDX_INIT = IDX_W'(N_INIT % CNT_W'(NCORES));
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NCORES - 1);

  logic [X_W-1:0]   x_slice [NCORES];
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] n_q, n_d;

  for (genvar k = 0; k < NCORES; k++) begin : g_slice
    assign x_slice[k] = core_state_i[k*STATE_W + KEEP_LSB +: X_W];
  end

  always_comb begin
    idx_d = idx_q;
    n_d   = n_q;
    if (advance_i) begin
      n_d = n_q + 1'b1;
      if (n_q == '1 || idx_q == IDX_LAST) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_INIT;
      n_q   <= N_INIT;
    end else if (advance_i) begin
      idx_q <= idx_d;
      n_q   <= n_d;
    end
  end

  assign idx_o = idx_q;
  assign n_o   = n_q;
  assign x_o   = x_slice[idx_q];
endmodule

// File: rtl/ltf_frame_ser.sv
`timescale 1ns/1ps
module ltf_frame_ser #(
  parameter int unsigned FRAME_BYTES = 9,
  parameter int unsigned FREE_W      = 8,
  localparam int unsigned FRAME_W    = FRAME_BYTES * ltf_pkg::BYTE_W,
  localparam int unsigned LEFT_W     = ltf_pkg::width_of(FRAME_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [FREE_W-1:0]    free_i,
  input  logic [FRAME_W-1:0]   payload_i,
  output logic                 start_o,
  output logic                 wr_en_o,
  output ltf_pkg::byte_t       data_o
);
  import ltf_pkg::*;

  ser_state_e        state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               pend_q, pend_d;
  logic               want, room, sh_en;

  always_comb begin
    want    = pend_q | tick_i;
    room    = (free_i >= FREE_W'(FRAME_BYTES));
    start_o = want && (state_q == SER_IDLE) && room;
    pend_d  = want && !start_o;
    state_d = state_q;
    sh_d    = sh_q;
    left_d  = left_q;
    unique case (state_q)
      SER_IDLE: begin
        if (start_o) begin
          sh_d    = payload_i;
          left_d  = LEFT_W'(FRAME_BYTES);
          state_d = SER_SEND;
        end
      end
      SER_SEND: begin
        sh_d   = sh_q << BYTE_W;
        left_d = left_q - 1'b1;
        if (left_q == LEFT_W'(1)) begin
          state_d = SER_IDLE;
        end
      end
      default: state_d = SER_IDLE;
    endcase
    sh_en = start_o || (state_q == SER_SEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      left_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign wr_en_o = (state_q == SER_SEND);
  assign data_o  = sh_q[FRAME_W-1 -: BYTE_W];
endmodule

// File: rtl/lattice_tlm_framer.sv
`timescale 1ns/1ps
module lattice_tlm_framer #(
  parameter int unsigned NCORES   = 49,
  parameter int unsigned STATE_W  = 32,
  parameter int unsigned KEEP_LSB = 8,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned FREE_W   = 8,
  parameter logic [7:0]  SYNC     = 8'hA5,
  parameter logic [CNT_W-1:0] N_INIT = '0,
  localparam int unsigned IDX_W       = ltf_pkg::width_of(NCORES),
  localparam int unsigned X_W         = STATE_W - KEEP_LSB,
  localparam int unsigned N_BYTES     = CNT_W / ltf_pkg::BYTE_W,
  localparam int unsigned X_BYTES     = X_W / ltf_pkg::BYTE_W,
  localparam int unsigned FRAME_BYTES = 2 + N_BYTES + X_BYTES,
  localparam int unsigned FRAME_W     = FRAME_BYTES * ltf_pkg::BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DIV_W-1:0]          tick_div_i,
  input  logic [NCORES*STATE_W-1:0] core_state_i,
  input  logic [FREE_W-1:0]         fifo_free_i,
  output logic                      fifo_wr_en_o,
  output logic [7:0]                fifo_wr_data_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic               tick;
  logic               start;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   n_cnt;
  logic [X_W-1:0]     x_val;
  logic [FRAME_W-1:0] payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ltf_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .div_i  (tick_div_i),
    .tick_o (tick)
  );

  ltf_core_sel #(
    .NCORES   (NCORES),
    .STATE_W  (STATE_W),
    .KEEP_LSB (KEEP_LSB),
    .CNT_W    (CNT_W),
    .N_INIT   (N_INIT)
  ) u_sel (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .advance_i    (start),
    .core_state_i (core_state_i),
    .idx_o        (idx),
    .n_o          (n_cnt),
    .x_o          (x_val)
  );

  assign payload = {SYNC, 8'(idx), n_cnt, x_val};

  ltf_frame_ser #(
    .FRAME_BYTES (FRAME_BYTES),
    .FREE_W      (FREE_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick),
    .free_i    (fifo_free_i),
    .payload_i (payload),
    .start_o   (start),
    .wr_en_o   (fifo_wr_en_o),
    .data_o    (fifo_wr_data_o)
  );
endmodule

// File: rtl/ltf_checker.sv
`timescale 1ns/1ps
module ltf_checker #(
  parameter int unsigned NCORES      = 49,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned FREE_W      = 8,
  parameter int unsigned FRAME_BYTES = 9,
  parameter int unsigned N_BYTES     = 4,
  parameter logic [7:0]  SYNC        = 8'hA5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FREE_W-1:0] fifo_free_i,
  input logic              fifo_wr_en_o,
  input logic [7:0]        fifo_wr_data_o
);
  localparam int unsigned RUN_W = ltf_pkg::width_of(FRAME_BYTES + 1) + 1;
  localparam int unsigned X_POS = 2 + N_BYTES;

  logic [RUN_W-1:0] run_q;
  logic [7:0]       idx_cap;
  logic [CNT_W-1:0] n_cap;
  logic [CNT_W-1:0] prev_n;
  logic             have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      idx_cap   <= '0;
      n_cap     <= '0;
      prev_n    <= '0;
      have_prev <= 1'b0;
    end else begin
      run_q <= fifo_wr_en_o ? run_q + 1'b1 : '0;
      if (fifo_wr_en_o && int'(run_q) == 1) begin
        idx_cap <= fifo_wr_data_o;
      end
      if (fifo_wr_en_o && int'(run_q) >= 2 && int'(run_q) < X_POS) begin
        n_cap <= {n_cap[CNT_W-9:0], fifo_wr_data_o};
      end
      if (fifo_wr_en_o && int'(run_q) == X_POS) begin
        prev_n    <= n_cap;
        have_prev <= 1'b1;
      end
    end
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_wr_en_o) |-> (int'(run_q) == FRAME_BYTES));

  p_run_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= FRAME_BYTES);

  p_sync_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en_o && run_q == '0) |-> (fifo_wr_data_o == SYNC));

  p_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en_o && run_q == '0) |-> (int'($past(fifo_free_i)) >= FRAME_BYTES));

  p_idx_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en_o && int'(run_q) == X_POS) |->
      (CNT_W'(idx_cap) == (n_cap % CNT_W'(NCORES))));

  p_n_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en_o && int'(run_q) == X_POS && have_prev) |->
      (n_cap == prev_n + 1'b1));
endmodule

bind lattice_tlm_framer ltf_checker #(
  .NCORES      (NCORES),
  .CNT_W       (CNT_W),
  .FREE_W      (FREE_W),
  .FRAME_BYTES (FRAME_BYTES),
  .N_BYTES     (N_BYTES),
  .SYNC        (SYNC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fifo_free_i    (fifo_free_i),
  .fifo_wr_en_o   (fifo_wr_en_o),
  .fifo_wr_data_o (fifo_wr_data_o)
);

// File: tb/lattice_tlm_framer_bench.sv
`timescale 1ns/1ps
module lattice_tlm_framer_bench;
  localparam int NC = 49;
  localparam int SW = 32;
  localparam logic [31:0] NI = 32'h00FF_FFF6;

  logic              clk;
  logic              rst_n;
  logic [15:0]       tick_div;
  logic [7:0]        fifo_free;
  logic [NC*SW-1:0]  states;
  logic              wr_en;
  logic [7:0]        wr_data;
  logic [7:0]        lowcnt;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 0;

  byte unsigned bq[$];
  int           sq[$];

  logic [31:0] exp_n;
  logic [31:0] last_n [NC];
  bit          seen   [NC];

  lattice_tlm_framer #(.N_INIT(NI)) u_lattice_tlm_framer (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_div_i     (tick_div),
    .core_state_i   (states),
    .fifo_free_i    (fifo_free),
    .fifo_wr_en_o   (wr_en),
    .fifo_wr_data_o (wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] xf(input int k);
    return {8'(k * 7 + 1), 8'(k ^ 8'h3C), 8'(255 - k)};
  endfunction

  always_comb begin
    for (int k = 0; k < NC; k++) states[k*SW +: SW] = {xf(k), lowcnt};
  end

  always @(negedge clk) begin
    lowcnt <= lowcnt + 8'd37;
    if (rst_n && wr_en) begin
      bq.push_back(wr_data);
      sq.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic get_frame(output bit got, output logic [7:0] idx,
                           output logic [31:0] n, output logic [23:0] x,
                           output int st);
    byte unsigned b [9];
    int           s [9];
    int           w = 0;
    got = 0; idx = '0; n = '0; x = '0; st = 0;
    while (bq.size() < 9 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (bq.size() < 9) begin
      chk(0, "R1", "frame timeout bytes", bq.size(), 9);
      return;
    end
    for (int i = 0; i < 9; i++) begin
      b[i] = bq.pop_front();
      s[i] = sq.pop_front();
    end
    chk(b[0] == 8'hA5, "R1", "sync byte", b[0], 8'hA5);
    chk(s[8] - s[0] == 8, "R1", "byte contiguity", s[8] - s[0], 8);
    idx = b[1];
    n   = {b[2], b[3], b[4], b[5]};
    x   = {b[6], b[7], b[8]};
    st  = s[0];
    got = 1;
  endtask

  task automatic check_frame(input logic [7:0] idx, input logic [31:0] n,
                             input logic [23:0] x);
    chk(n == exp_n, "R3", "counter step", n, exp_n);
    chk(32'(idx) == n % NC, "R2", "index vs n mod 49", idx, n % NC);
    if (idx < NC) begin
      chk(x == xf(idx), "R5", "state bits 31:8", x, xf(idx));
      if (seen[idx]) chk(n - last_n[idx] == 49, "R4", "per-core spacing",
                         n - last_n[idx], 49);
      seen[idx]   = 1;
      last_n[idx] = n;
    end
    exp_n = n + 1;
  endtask

  task automatic t_reset();
    bit ok = 1;
    logic [7:0] idx; logic [31:0] n; logic [23:0] x; int st; bit got;
    rst_n = 0; tick_div = 16'd0; fifo_free = 8'd64;
    repeat (12) begin
      @(negedge clk);
      if (wr_en !== 1'b0) ok = 0;
    end
    chk(ok, "R8", "no write during reset", wr_en, 0);
    rst_n = 1;
    get_frame(got, idx, n, x, st);
    chk(n == NI, "R8", "first counter value", n, NI);
    chk(32'(idx) == NI % NC, "R8", "first core index", idx, NI % NC);
    exp_n = NI;
    if (got) check_frame(idx, n, x);
  endtask

  task automatic t_stream();
    logic [7:0] idx; logic [31:0] n; logic [23:0] x; int st; bit got;
    int prev_st = -1;
    bit crossed = 0;
    for (int i = 0; i < 120; i++) begin
      get_frame(got, idx, n, x, st);
      if (!got) return;
      check_frame(idx, n, x);
      if (prev_st >= 0) chk(st - prev_st == 10, "R7", "spacing at D=0",
                            st - prev_st, 10);
      prev_st = st;
      if (n == 32'h0100_0000) begin
        crossed = 1;
        chk(idx == 8'd8, "R3", "core at 2^24", idx, 8);
      end
    end
    chk(crossed, "R3", "2^24 crossing seen", crossed, 1);
  endtask

  task automatic t_room();
    logic [7:0] idx; logic [31:0] n; logic [23:0] x; int st; bit got;
    fifo_free = 8'd8;
    repeat (20) @(negedge clk);
    while (bq.size() >= 9) begin
      get_frame(got, idx, n, x, st);
      check_frame(idx, n, x);
    end
    chk(bq.size() == 0, "R6", "no partial frame", bq.size(), 0);
    repeat (200) @(negedge clk);
    chk(bq.size() == 0, "R6", "no write with 8 free", bq.size(), 0);
    fifo_free = 8'd9;
    get_frame(got, idx, n, x, st);
    chk(got, "R6", "frame with 9 free", got, 1);
    if (got) check_frame(idx, n, x);
  endtask

  task automatic t_rate();
    logic [7:0] idx; logic [31:0] n; logic [23:0] x; int st; bit got;
    int sts [4];
    fifo_free = 8'd64;
    tick_div  = 16'd19;
    repeat (60) @(negedge clk);
    while (bq.size() >= 9) begin
      get_frame(got, idx, n, x, st);
      check_frame(idx, n, x);
    end
    for (int i = 0; i < 4; i++) begin
      get_frame(got, idx, n, x, st);
      if (!got) return;
      check_frame(idx, n, x);
      sts[i] = st;
    end
    for (int i = 1; i < 4; i++)
      chk(sts[i] - sts[i-1] == 20, "R7", "spacing at D=19",
          sts[i] - sts[i-1], 20);
  endtask

  initial begin
    lowcnt = 8'd0;
    for (int k = 0; k < NC; k++) begin
      seen[k] = 0;
      last_n[k] = '0;
    end
    t_reset();
    t_stream();
    t_room();
    t_rate();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule